// File: doc/BRIEF.md
# Sub-Dword Operand Select and Merge Unit

This unit sits on both sides of a 32-bit per-lane arithmetic stage. On the source side it picks one byte, one 16-bit half or the whole 32-bit word out of every lane of an operand vector. It widens the picked field to 32 bits with zeros or with copies of its top bit, and then applies an optional magnitude or negation modifier. The arithmetic stage consumes that conditioned operand.

On the destination side the unit takes the 32-bit result of each lane and writes it into a chosen byte, half or full word of the destination. It can first saturate the result to the largest unsigned value the chosen field can hold. The destination bits outside the field are either cleared, filled with the field's top bit, or kept from the previous destination value.

All lanes share one set of controls and each lane works on its own data. Both paths settle combinationally, and their results are captured in a single output register stage. A reserved select code raises an error flag.

Top module: `sdw_operand_unit`

## Requirements
- R1: A synchronous active-low reset clears `opnd_out`, `dst_out` and `sel_err` to zero on the clock edge at which reset is sampled low.
- R2: Select codes pick the field for both paths. Codes 0 to 3 pick byte k at bits [8k+7:8k], code 4 picks bits [15:0], code 5 picks bits [31:16] and code 6 picks all 32 bits. With `src_sext` low, a byte or half field is zero-padded to 32 bits.
- R3: With `src_sext` high, a byte or half source field is sign-extended from its top bit (bit 7 or bit 15 of the field). A full-word field is passed unchanged.
- R4: With `src_abs` high, the extended source value is replaced by its two's-complement magnitude and `src_neg` is ignored. The value 0x80000000 stays 0x80000000.
- R5: With `src_neg` high and `src_abs` low, the extended source value is replaced by its two's-complement negation.
- R6: For a byte or half destination select, the low bits of the (possibly clamped) result are placed at the selected field position of `dst_out`.
- R7: Fill code 0 clears every destination bit outside the field. The reserved fill code 3 behaves the same way.
- R8: Fill code 1 copies the top bit of the written field into every bit above the field and clears the bits below it.
- R9: Fill code 2 takes every bit outside the field from `old_dst` of the same lane.
- R10: With `dst_clamp` high and a byte or half destination, a result above 255 (byte) or 65535 (half), compared as unsigned, is written as that maximum. Without clamp the result is truncated to the field.
- R11: Destination select code 6 writes the full 32-bit result, and fill code and clamp have no effect.
- R12: Select code 7 on either path drives that path's output for all lanes to zero and sets `sel_err` one cycle later. `sel_err` is low one cycle after a cycle with no code 7 on either path.
- R13: Every output reflects the inputs present at the preceding clock edge, and each lane is computed from its own data only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_data | input | LANES*32 | Source operand, lane k in bits [32k+31:32k] |
| src_sel | input | 3 | Source field select code |
| src_sext | input | 1 | Sign-extend the source field |
| src_abs | input | 1 | Take source magnitude (wins over negate) |
| src_neg | input | 1 | Negate source |
| res_data | input | LANES*32 | Arithmetic result per lane |
| old_dst | input | LANES*32 | Previous destination value per lane |
| dst_sel | input | 3 | Destination field select code |
| dst_fill | input | 2 | Unused-bit policy: 0 clear, 1 sign, 2 keep, 3 clear |
| dst_clamp | input | 1 | Saturate result to field maximum |
| opnd_out | output | LANES*32 | Registered conditioned source operand |
| dst_out | output | LANES*32 | Registered merged destination |
| sel_err | output | 1 | Registered reserved-select flag |

## Verification
The only state is the output register, so any fault in extraction, extension, modifier, clamp or fill logic appears at `opnd_out` or `dst_out` on the first edge after the offending inputs. It shows as specific wrong bit ranges: the field itself, the bits above it or the bits below it. A lane that used another lane's data, or a stale register, shows as a mismatch in that lane on the next cycle. The bench therefore compares every lane of both outputs and the error flag against a bit-by-bit model after every edge. It does this under directed corner values and back-to-back random traffic.

// File: rtl/sdw_pkg.sv
// Shared types and field helpers for the sub-dword operand unit.
// Assumes a fixed 32-bit lane word; field codes are shared by both paths.
package sdw_pkg;
    localparam int unsigned WORD_W = 32;

    typedef enum logic [2:0] {
        FS_BYTE0 = 3'd0,
        FS_BYTE1 = 3'd1,
        FS_BYTE2 = 3'd2,
        FS_BYTE3 = 3'd3,
        FS_HALF0 = 3'd4,
        FS_HALF1 = 3'd5,
        FS_FULL  = 3'd6,
        FS_BAD   = 3'd7
    } fsel_e;

    typedef enum logic [1:0] {
        UF_ZERO = 2'd0,
        UF_SIGN = 2'd1,
        UF_KEEP = 2'd2,
        UF_RSVD = 2'd3
    } ufill_e;

    // Bit position of the field's least significant bit.
    function automatic logic [4:0] fsel_lsb(fsel_e s);
        case (s)
            FS_BYTE1: return 5'd8;
            FS_BYTE2: return 5'd16;
            FS_BYTE3: return 5'd24;
            FS_HALF1: return 5'd16;
            default:  return 5'd0;
        endcase
    endfunction

    // Right-aligned mask covering the field width.
    function automatic logic [WORD_W-1:0] fsel_mask(fsel_e s);
        case (s)
            FS_BYTE0, FS_BYTE1, FS_BYTE2, FS_BYTE3: return WORD_W'(8'hFF);
            FS_HALF0, FS_HALF1:                     return WORD_W'(16'hFFFF);
            default:                                return {WORD_W{1'b1}};
        endcase
    endfunction
endpackage

// File: rtl/sdw_src_lane.sv
// Source conditioning for one lane: extract a field, widen it with zeros or
// sign copies, then apply magnitude (priority) or negation.
// Assumes the select code is stable for the cycle; code FS_BAD yields zero.
module sdw_src_lane
    import sdw_pkg::*;
(
    input  logic [WORD_W-1:0] src_i,
    input  fsel_e             sel_i,
    input  logic              sext_i,
    input  logic              abs_i,
    input  logic              neg_i,
    output logic [WORD_W-1:0] opnd_o
);
    logic [WORD_W-1:0] fmask;
    logic [WORD_W-1:0] topmask;
    logic [WORD_W-1:0] field;
    logic [WORD_W-1:0] widened;
    logic [WORD_W-1:0] modded;
    logic              top_bit;

    // Extract the selected field and widen it to a full word.
    always_comb begin
        fmask   = fsel_mask(sel_i);
        topmask = fmask ^ (fmask >> 1);
        field   = (src_i >> fsel_lsb(sel_i)) & fmask;
        top_bit = |(field & topmask);
        widened = field | ((sext_i && top_bit) ? ~fmask : '0);
    end

    // Apply the modifiers, magnitude taking priority over negation.
    always_comb begin
        if (abs_i)
            modded = widened[WORD_W-1] ? (~widened + 1'b1) : widened;
        else if (neg_i)
            modded = ~widened + 1'b1;
        else
            modded = widened;
        opnd_o = (sel_i == FS_BAD) ? '0 : modded;
    end

    // Check that a magnitude result is non-negative except the single wrap value.
    always_comb begin
        // R4
        abs_nonneg_chk: assert (!(abs_i && sel_i != FS_BAD) || !opnd_o[WORD_W-1]
                                || opnd_o == {1'b1, {(WORD_W-1){1'b0}}});
    end
endmodule

// File: rtl/sdw_dst_lane.sv
// Destination merge for one lane: optional unsigned saturation to the field
// width, placement at the field position, and fill of the remaining bits.
// Assumes a full-word select bypasses fill and clamp; FS_BAD yields zero.
module sdw_dst_lane
    import sdw_pkg::*;
(
    input  logic [WORD_W-1:0] res_i,
    input  logic [WORD_W-1:0] old_i,
    input  fsel_e             sel_i,
    input  ufill_e            fill_i,
    input  logic              clamp_i,
    output logic [WORD_W-1:0] dst_o
);
    logic [4:0]        lsb;
    logic [WORD_W-1:0] fmask;
    logic [WORD_W-1:0] topmask;
    logic [WORD_W-1:0] fval;
    logic [WORD_W-1:0] placed;
    logic [WORD_W-1:0] pmask;
    logic [WORD_W-1:0] below;
    logic [WORD_W-1:0] above;
    logic              over;
    logic              sgn;

    // Saturate or truncate the result to the field and position it.
    always_comb begin
        lsb     = fsel_lsb(sel_i);
        fmask   = fsel_mask(sel_i);
        topmask = fmask ^ (fmask >> 1);
        over    = |(res_i & ~fmask);
        fval    = (clamp_i && over) ? fmask : (res_i & fmask);
        placed  = fval << lsb;
        pmask   = fmask << lsb;
        below   = (WORD_W'(1) << lsb) - 1'b1;
        above   = ~(pmask | below);
        sgn     = |(fval & topmask);
    end

    // Fill the bits outside the field according to the policy.
    always_comb begin
        if (sel_i == FS_BAD)
            dst_o = '0;
        else if (sel_i == FS_FULL)
            dst_o = res_i;
        else begin
            case (fill_i)
                UF_SIGN: dst_o = placed | (sgn ? above : '0);
                UF_KEEP: dst_o = placed | (old_i & ~pmask);
                default: dst_o = placed;
            endcase
        end
    end

    // Check that the outside bits follow the keep and clear policies.
    always_comb begin
        // R9
        keep_outside_chk: assert (!(fill_i == UF_KEEP && sel_i != FS_FULL && sel_i != FS_BAD)
                                  || ((dst_o ^ old_i) & ~pmask) == '0);
        // R7
        clear_outside_chk: assert (!((fill_i == UF_ZERO || fill_i == UF_RSVD) && sel_i != FS_FULL)
                                   || (dst_o & ~pmask) == '0);
    end
endmodule

// File: rtl/sdw_operand_unit.sv
// Vector sub-dword operand unit: one source conditioner and one destination
// merger per lane, all lanes sharing the control inputs, results registered.
// Assumes a synchronous active-low reset and a single clock.
module sdw_operand_unit
    import sdw_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES*WORD_W-1:0]   src_data,
    input  logic [2:0]                src_sel,
    input  logic                      src_sext,
    input  logic                      src_abs,
    input  logic                      src_neg,
    input  logic [LANES*WORD_W-1:0]   res_data,
    input  logic [LANES*WORD_W-1:0]   old_dst,
    input  logic [2:0]                dst_sel,
    input  logic [1:0]                dst_fill,
    input  logic                      dst_clamp,
    output logic [LANES*WORD_W-1:0]   opnd_out,
    output logic [LANES*WORD_W-1:0]   dst_out,
    output logic                      sel_err
);
    localparam int unsigned BUS_W = LANES * WORD_W;

    fsel_e             s_sel;
    fsel_e             d_sel;
    ufill_e            d_fill;
    logic [BUS_W-1:0]  opnd_nx;
    logic [BUS_W-1:0]  dst_nx;
    logic              err_nx;

    // Decode the shared control codes into typed form.
    always_comb begin
        s_sel  = fsel_e'(src_sel);
        d_sel  = fsel_e'(dst_sel);
        d_fill = ufill_e'(dst_fill);
        err_nx = (s_sel == FS_BAD) || (d_sel == FS_BAD);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sdw_src_lane u_src (
            .src_i  (src_data[g*WORD_W +: WORD_W]),
            .sel_i  (s_sel),
            .sext_i (src_sext),
            .abs_i  (src_abs),
            .neg_i  (src_neg),
            .opnd_o (opnd_nx[g*WORD_W +: WORD_W])
        );
        sdw_dst_lane u_dst (
            .res_i   (res_data[g*WORD_W +: WORD_W]),
            .old_i   (old_dst[g*WORD_W +: WORD_W]),
            .sel_i   (d_sel),
            .fill_i  (d_fill),
            .clamp_i (dst_clamp),
            .dst_o   (dst_nx[g*WORD_W +: WORD_W])
        );
    end

    // Capture both paths and the error flag in the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_out <= '0;
            dst_out  <= '0;
            sel_err  <= 1'b0;
        end else begin
            opnd_out <= opnd_nx;
            dst_out  <= dst_nx;
            sel_err  <= err_nx;
        end
    end

    // R12
    src_bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'd7) |=> sel_err);

    // R12
    dst_bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_sel == 3'd7) |=> (dst_out == '0 && sel_err));

    // R12
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel != 3'd7 && dst_sel != 3'd7) |=> !sel_err);

    // R11
    full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_sel == 3'd6) |=> (dst_out == $past(res_data)));
endmodule

// File: tb/sim_sdw_operand_unit.sv
module sim_sdw_operand_unit;
    localparam int LANES = 4;
    localparam int BW = LANES * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [BW-1:0] src_data = '0;
    logic [2:0]    src_sel = 3'd0;
    logic          src_sext = 1'b0;
    logic          src_abs = 1'b0;
    logic          src_neg = 1'b0;
    logic [BW-1:0] res_data = '0;
    logic [BW-1:0] old_dst = '0;
    logic [2:0]    dst_sel = 3'd0;
    logic [1:0]    dst_fill = 2'd0;
    logic          dst_clamp = 1'b0;
    logic [BW-1:0] opnd_out;
    logic [BW-1:0] dst_out;
    logic          sel_err;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sdw_operand_unit #(.LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n),
        .src_data(src_data), .src_sel(src_sel), .src_sext(src_sext),
        .src_abs(src_abs), .src_neg(src_neg),
        .res_data(res_data), .old_dst(old_dst), .dst_sel(dst_sel),
        .dst_fill(dst_fill), .dst_clamp(dst_clamp),
        .opnd_out(opnd_out), .dst_out(dst_out), .sel_err(sel_err)
    );

    function automatic logic [31:0] ref_src(logic [31:0] v, int s, bit sx, bit ab, bit ng);
        int w, lo;
        logic [31:0] f;
        if (s == 7) return 32'h0;
        if (s < 4) begin w = 8; lo = 8 * s; end
        else if (s == 4) begin w = 16; lo = 0; end
        else if (s == 5) begin w = 16; lo = 16; end
        else begin w = 32; lo = 0; end
        f = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < w) f[i] = v[lo + i];
            else f[i] = sx ? v[lo + w - 1] : 1'b0;
        end
        if (ab) begin
            if (f[31]) f = 32'h0 - f;
        end else if (ng) begin
            f = 32'h0 - f;
        end
        return f;
    endfunction

    function automatic logic [31:0] ref_dst(logic [31:0] r, logic [31:0] od, int s, int fl, bit cl);
        int w, lo;
        logic [31:0] maxv, fv, o;
        if (s == 7) return 32'h0;
        if (s == 6) return r;
        if (s < 4) begin w = 8; lo = 8 * s; maxv = 32'd255; end
        else begin w = 16; lo = (s == 5) ? 16 : 0; maxv = 32'd65535; end
        fv = (cl && r > maxv) ? maxv : (r % (maxv + 1));
        o = '0;
        for (int i = 0; i < 32; i++) begin
            if (i >= lo && i < lo + w) o[i] = fv[i - lo];
            else if (fl == 2) o[i] = od[i];
            else if (fl == 1 && i >= lo + w) o[i] = fv[w - 1];
            else o[i] = 1'b0;
        end
        return o;
    endfunction

    task automatic cmp32(string tag, string what, int lane, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s lane %0d got %h expected %h", tag, what, lane, got, exp);
        end
    endtask

    // Compute expectation from current inputs, clock once, compare off-edge.
    task automatic step(string tag);
        logic [31:0] eo [LANES];
        logic [31:0] ed [LANES];
        logic ee;
        for (int k = 0; k < LANES; k++) begin
            eo[k] = rst_n ? ref_src(src_data[k*32 +: 32], int'(src_sel), src_sext, src_abs, src_neg) : 32'h0;
            ed[k] = rst_n ? ref_dst(res_data[k*32 +: 32], old_dst[k*32 +: 32], int'(dst_sel),
                                    int'(dst_fill), dst_clamp) : 32'h0;
        end
        ee = rst_n && (src_sel == 3'd7 || dst_sel == 3'd7);
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < LANES; k++) begin
            cmp32(tag, "opnd", k, opnd_out[k*32 +: 32], eo[k]);
            cmp32(tag, "dst", k, dst_out[k*32 +: 32], ed[k]);
        end
        cmp32(tag, "err", 0, {31'b0, sel_err}, {31'b0, ee});
    endtask

    task automatic fill_lanes(logic [31:0] sv, logic [31:0] rv, logic [31:0] ov);
        for (int k = 0; k < LANES; k++) begin
            src_data[k*32 +: 32] = sv ^ (32'h0101_0101 * k);
            res_data[k*32 +: 32] = rv + 32'(k * 32'h0000_0111);
            old_dst[k*32 +: 32]  = ov ^ (32'h1000_0001 * k);
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 reset clears outputs even with illegal/nonzero inputs present
        fill_lanes(32'hDEAD_BEEF, 32'h1234_5678, 32'hFFFF_FFFF);
        src_sel = 3'd7; dst_sel = 3'd7;
        step("R1");
        step("R1");
        rst_n = 1'b1;

        // R2 every legal source select, zero padding
        fill_lanes(32'hA1B2_C3D4, 32'h0, 32'h0);
        dst_sel = 3'd6;
        for (int s = 0; s < 7; s++) begin src_sel = 3'(s); step("R2"); end

        // R3 sign extension of byte, half, and full word
        src_sext = 1'b1;
        fill_lanes(32'h80F0_8081, 32'h0, 32'h0);
        for (int s = 0; s < 7; s++) begin src_sel = 3'(s); step("R3"); end

        // R4 magnitude wins over negate, and the wrap value
        src_abs = 1'b1; src_neg = 1'b1;
        src_sel = 3'd5; step("R4");
        src_sel = 3'd0; step("R4");
        src_sext = 1'b0; src_sel = 3'd6;
        fill_lanes(32'h8000_0000, 32'h0, 32'h0); step("R4");
        fill_lanes(32'h0000_0005, 32'h0, 32'h0); step("R4");

        // R5 negate alone
        src_abs = 1'b0;
        src_sel = 3'd0; step("R5");
        src_sext = 1'b1; src_sel = 3'd4;
        fill_lanes(32'h0000_FFFE, 32'h0, 32'h0); step("R5");
        src_neg = 1'b0; src_sext = 1'b0;

        // R6 placement into each byte/half, cleared fill
        fill_lanes(32'h0, 32'h0000_12C5, 32'hCAFE_F00D);
        dst_fill = 2'd0;
        for (int s = 0; s < 6; s++) begin dst_sel = 3'(s); step("R6"); end

        // R7 reserved fill code clears too
        dst_fill = 2'd3;
        for (int s = 0; s < 6; s++) begin dst_sel = 3'(s); step("R7"); end

        // R8 sign fill above the field
        dst_fill = 2'd1;
        fill_lanes(32'h0, 32'h0000_80F5, 32'hCAFE_F00D);
        for (int s = 0; s < 6; s++) begin dst_sel = 3'(s); step("R8"); end

        // R9 keep the old destination outside the field
        dst_fill = 2'd2;
        for (int s = 0; s < 6; s++) begin dst_sel = 3'(s); step("R9"); end

        // R10 clamp saturates over-range results, leaves in-range ones
        dst_clamp = 1'b1; dst_fill = 2'd0;
        fill_lanes(32'h0, 32'h0001_2345, 32'h0);
        dst_sel = 3'd1; step("R10");
        dst_sel = 3'd5; step("R10");
        fill_lanes(32'h0, 32'h0000_00FE, 32'h0);
        dst_sel = 3'd2; step("R10");
        dst_clamp = 1'b0;
        fill_lanes(32'h0, 32'h0001_2345, 32'h0);
        dst_sel = 3'd1; step("R10");

        // R11 full-word destination ignores fill and clamp
        dst_sel = 3'd6; dst_clamp = 1'b1; dst_fill = 2'd2;
        fill_lanes(32'h0, 32'hF00D_1234, 32'h5555_AAAA);
        step("R11");
        dst_fill = 2'd1; step("R11");

        // R12 reserved select on each path, then clear
        src_sel = 3'd7; dst_sel = 3'd0; step("R12");
        src_sel = 3'd2; dst_sel = 3'd7; step("R12");
        dst_sel = 3'd3; step("R12");

        // R13 back-to-back random traffic, per-lane data
        for (int n = 0; n < 400; n++) begin
            for (int k = 0; k < LANES; k++) begin
                src_data[k*32 +: 32] = $urandom;
                res_data[k*32 +: 32] = (n % 3 == 0) ? ($urandom & 32'h1FF) : $urandom;
                old_dst[k*32 +: 32]  = $urandom;
            end
            src_sel = 3'($urandom % 8); dst_sel = 3'($urandom % 8);
            src_sext = 1'($urandom); src_abs = 1'($urandom); src_neg = 1'($urandom);
            dst_fill = 2'($urandom); dst_clamp = 1'($urandom);
            step("R13");
        end

        // R1 reset in mid-run clears again
        rst_n = 1'b0;
        step("R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule